// File: doc/BRIEF.md
# Trigger Race Decoder with Number Capture

This block watches two active-low trigger handshake lines, a start-digitize line and a hold-transfer line. Both rest high and each marks an event by going low. The block decides which line falls first. A hold-transfer line falling while start-digitize is still high latches a sticky readout-request flag. A start-digitize line falling while hold-transfer is still high latches a sticky dump flag. If both falls land in the same sampled clock cycle, neither flag is set and a one-cycle ambiguous-order pulse is raised instead. The host clears both flags with a readout-done pulse.

Alongside the race decision, the block captures a trigger number when the hold-transfer line returns high. It holds that number on its output until the next return-high edge. It also merges the local readout busy and the engine busy into one front-end busy output.

The two lines and the number arrive from outside the clock domain, so they pass through two-stage synchronisers. The number is delayed by the same amount as the lines, which lines up the capture with the synchronised edge. The flags, the number and the busy output are plain level signals. None of them has a handshake.

Top module: `trig_race_decoder`

## Requirements
- R1: Both lines are synchronised through two flip-flops. A line change that is set up before clock edge k shows on a flag output just after edge k+2, and not before.
- R2: When the synchronised hold-transfer line falls while start-digitize is high, `readout_req_o` goes to 1 and stays 1.
- R3: When the synchronised start-digitize line falls while hold-transfer is high, `dump_evt_o` goes to 1 and stays 1.
- R4: `readout_done_i` high at a clock edge clears both `readout_req_o` and `dump_evt_o` at that edge.
- R5: On each synchronised low-to-high transition of hold-transfer, `trig_num_o` loads the trigger number that was present with that transition. It holds that value until the next such transition.
- R6: If both lines are seen falling in the same sampled cycle, neither flag changes and `order_amb_o` is 1 for exactly one cycle.
- R7: `fe_busy_o` is 1 whenever `local_busy_i` or `engine_busy_i` is 1, and 0 otherwise. There is no clock delay.
- R8: A synchronous active-high `rst_i` gives flags 0, `order_amb_o` 0 and `trig_num_o` 0. The synchronisers and edge detectors go to the idle-high state.
- R9: If `readout_done_i` is high at the edge where a deciding fall is seen, the clear wins and no flag is set by that fall.
- R10: After any decision (a flag set, an ambiguous pulse, or a fall that the clear suppressed), further falls make no decision until both synchronised lines have been high together again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_dig_ni | input | 1 | Start-digitize line, active low, asynchronous |
| hold_xfer_ni | input | 1 | Hold-transfer line, active low, asynchronous |
| trig_num_i | input | NUM_W | Trigger number, asynchronous |
| readout_done_i | input | 1 | Host clear of both flags, synchronous |
| local_busy_i | input | 1 | Local readout busy |
| engine_busy_i | input | 1 | Engine-control busy |
| readout_req_o | output | 1 | Sticky readout-request flag |
| dump_evt_o | output | 1 | Sticky dump flag |
| order_amb_o | output | 1 | One-cycle pulse when the fall order cannot be resolved |
| trig_num_o | output | NUM_W | Last captured trigger number |
| fe_busy_o | output | 1 | Combined front-end busy |

## Verification
The bench goes after these cases:
- Both lines falling in the same sampled cycle. A design that ranked one line over the other would set a flag here instead of pulsing the ambiguous output.
- A clear that lands exactly on the edge where a fall is decided. A design that let the set win would leave a flag standing after the host had cleared it.
- Falls that arrive before both lines have gone high again. A design that re-armed too early would make a second decision for one trigger.
- The cycle at which the number is captured. A number path with no delay, or the wrong delay, would load a value from the wrong moment.

// File: rtl/trd_pkg.sv
package trd_pkg;
  localparam int SYNC_DEPTH_DEF = 2;

  // Edge and level information from the synchronised handshake lines.
  // Levels are active-low lines as seen on the wire: 1 means idle.
  typedef struct packed {
    logic sd_lvl;
    logic ht_lvl;
    logic sd_fall;
    logic ht_fall;
    logic ht_rise;
  } trd_edges_t;
endpackage

// File: rtl/trd_sync.sv
module trd_sync #(
  parameter int          W       = 1,
  parameter int          DEPTH   = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int LAST = DEPTH - 1;

  logic [W-1:0] stg_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[LAST];
endmodule

// File: rtl/trd_edge.sv
module trd_edge
  import trd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       sd_s_i,
  input  logic       ht_s_i,
  output trd_edges_t edges_o
);
  logic sd_prev_q;
  logic ht_prev_q;

  // Previous levels reset to idle-high so that reset itself makes no edge.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sd_prev_q <= 1'b1;
      ht_prev_q <= 1'b1;
    end else begin
      sd_prev_q <= sd_s_i;
      ht_prev_q <= ht_s_i;
    end
  end

  always_comb begin
    edges_o.sd_lvl  = sd_s_i;
    edges_o.ht_lvl  = ht_s_i;
    edges_o.sd_fall = sd_prev_q & ~sd_s_i;
    edges_o.ht_fall = ht_prev_q & ~ht_s_i;
    edges_o.ht_rise = ~ht_prev_q & ht_s_i;
  end
endmodule

// File: rtl/trd_order_arb.sv
module trd_order_arb
  import trd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  trd_edges_t edges_i,
  input  logic       clr_i,
  output logic       rorq_o,
  output logic       dump_o,
  output logic       amb_o
);
  logic armed_q;
  logic both_idle;
  logic any_fall;
  logic pick_amb;
  logic pick_dump;
  logic pick_rorq;

  always_comb begin
    both_idle = edges_i.sd_lvl & edges_i.ht_lvl;
    any_fall  = armed_q & (edges_i.sd_fall | edges_i.ht_fall);
    pick_amb  = armed_q & edges_i.sd_fall & edges_i.ht_fall;
    pick_dump = armed_q & edges_i.sd_fall & edges_i.ht_lvl;
    pick_rorq = armed_q & edges_i.ht_fall & edges_i.sd_lvl;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rorq_o  <= 1'b0;
      dump_o  <= 1'b0;
      amb_o   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      amb_o <= 1'b0;
      if (any_fall) begin
        armed_q <= 1'b0;
      end else if (both_idle) begin
        armed_q <= 1'b1;
      end
      if (clr_i) begin
        rorq_o <= 1'b0;
        dump_o <= 1'b0;
      end else if (pick_amb) begin
        amb_o <= 1'b1;
      end else if (pick_dump) begin
        dump_o <= 1'b1;
      end else if (pick_rorq) begin
        rorq_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trd_num_cap.sv
module trd_num_cap #(
  parameter int NUM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [NUM_W-1:0] num_i,
  output logic [NUM_W-1:0] num_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      num_o <= '0;
    end else if (load_i) begin
      num_o <= num_i;
    end
  end
endmodule

// File: rtl/trig_race_decoder.sv
module trig_race_decoder
  import trd_pkg::*;
#(
  parameter int NUM_W      = 16,
  parameter int SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_dig_ni,
  input  logic             hold_xfer_ni,
  input  logic [NUM_W-1:0] trig_num_i,
  input  logic             readout_done_i,
  input  logic             local_busy_i,
  input  logic             engine_busy_i,
  output logic             readout_req_o,
  output logic             dump_evt_o,
  output logic             order_amb_o,
  output logic [NUM_W-1:0] trig_num_o,
  output logic             fe_busy_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] lines_raw;
  logic [LINES-1:0] lines_s;
  logic [NUM_W-1:0] num_s;
  trd_edges_t       edges_w;
  logic             ht_rise_w;

  assign lines_raw = {start_dig_ni, hold_xfer_ni};

  trd_sync #(.W(LINES), .DEPTH(SYNC_DEPTH), .RST_VAL({LINES{1'b1}})) u_line_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(lines_raw), .q_o(lines_s)
  );

  trd_sync #(.W(NUM_W), .DEPTH(SYNC_DEPTH), .RST_VAL({NUM_W{1'b0}})) u_num_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(trig_num_i), .q_o(num_s)
  );

  trd_edge u_edge (
    .clk_i(clk_i), .rst_i(rst_i),
    .sd_s_i(lines_s[1]), .ht_s_i(lines_s[0]),
    .edges_o(edges_w)
  );

  assign ht_rise_w = edges_w.ht_rise;

  trd_order_arb u_arb (
    .clk_i(clk_i), .rst_i(rst_i), .edges_i(edges_w), .clr_i(readout_done_i),
    .rorq_o(readout_req_o), .dump_o(dump_evt_o), .amb_o(order_amb_o)
  );

  trd_num_cap #(.NUM_W(NUM_W)) u_cap (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(ht_rise_w),
    .num_i(num_s), .num_o(trig_num_o)
  );

  assign fe_busy_o = local_busy_i | engine_busy_i;
endmodule

// File: rtl/trd_checker.sv
module trd_checker #(
  parameter int NUM_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             rorq,
  input logic             dump,
  input logic             amb,
  input logic             ht_rise,
  input logic [NUM_W-1:0] num,
  input logic             busy_a,
  input logic             busy_b,
  input logic             busy_y
);
  // R4
  clr_clears_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!rorq && !dump));

  // R6
  amb_single_chk: assert property (@(posedge clk) disable iff (rst)
    amb |=> !amb);

  // R6
  amb_noflag_chk: assert property (@(posedge clk) disable iff (rst)
    amb |-> (rorq == $past(rorq) && dump == $past(dump)));

  // R9
  rorq_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rorq) |-> !$past(clr));

  // R3
  dump_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dump) |-> (!$past(clr) && !amb));

  // R5
  num_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(ht_rise) |-> $stable(num));

  // R7
  busy_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_a && !busy_b) |-> !busy_y);
endmodule

bind trig_race_decoder trd_checker #(.NUM_W(NUM_W)) u_trd_chk (
  .clk(clk_i), .rst(rst_i), .clr(readout_done_i),
  .rorq(readout_req_o), .dump(dump_evt_o), .amb(order_amb_o),
  .ht_rise(ht_rise_w), .num(trig_num_o),
  .busy_a(local_busy_i), .busy_b(engine_busy_i), .busy_y(fe_busy_o)
);

// File: tb/trig_race_decoder_tb_top.sv
module trig_race_decoder_tb_top;
  localparam int NW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          sd_n, ht_n, clr, lbusy, ebusy;
  logic [NW-1:0] num_in;
  logic          rorq, dump, amb, busy;
  logic [NW-1:0] num_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit cmp_on = 0;

  always #5 clk = ~clk;

  trig_race_decoder #(.NUM_W(NW)) dut_i (
    .clk_i(clk), .rst_i(rst), .start_dig_ni(sd_n), .hold_xfer_ni(ht_n),
    .trig_num_i(num_in), .readout_done_i(clr), .local_busy_i(lbusy),
    .engine_busy_i(ebusy), .readout_req_o(rorq), .dump_evt_o(dump),
    .order_amb_o(amb), .trig_num_o(num_out), .fe_busy_o(busy)
  );

  // Behavioural reference: input history queues plus sticky state.
  bit [1:0]      lv_h[$];   // {sd, ht} as sampled at each edge, newest first
  bit [NW-1:0]   nm_h[$];
  bit m_rorq, m_dump, m_amb, m_arm;
  bit [NW-1:0] m_num;

  always @(posedge clk) begin
    if (rst) begin
      lv_h = '{2'b11, 2'b11, 2'b11, 2'b11};
      nm_h = '{0, 0, 0, 0};
      m_rorq = 0; m_dump = 0; m_amb = 0; m_arm = 0; m_num = 0;
    end else begin
      bit sd_now, ht_now, sd_old, ht_old, sdf, htf, decided;
      lv_h.push_front({sd_n, ht_n});
      nm_h.push_front(num_in);
      void'(lv_h.pop_back());
      sd_now = lv_h[2][1]; ht_now = lv_h[2][0];
      sd_old = lv_h[3][1]; ht_old = lv_h[3][0];
      sdf = sd_old && !sd_now;
      htf = ht_old && !ht_now;
      if (!ht_old && ht_now) m_num = nm_h[2];
      void'(nm_h.pop_back());
      m_amb = 0;
      decided = m_arm && (sdf || htf);
      if (clr) begin
        m_rorq = 0; m_dump = 0;
      end else if (decided) begin
        if (sdf && htf) m_amb = 1;
        else if (sdf && ht_now) m_dump = 1;
        else if (htf && sd_now) m_rorq = 1;
      end
      if (decided) m_arm = 0;
      else if (sd_now && ht_now) m_arm = 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R2 readout_req", rorq, m_rorq);
      chk("R3 dump_evt", dump, m_dump);
      chk("R6 order_amb", amb, m_amb);
      chk("R5 trig_num", num_out, m_num);
      chk("R7 fe_busy", busy, lbusy | ebusy);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_lines();
    sd_n = 1; ht_n = 1; cyc(4);
  endtask

  task automatic pulse_clr();
    clr = 1; cyc(1); clr = 0; cyc(1);
  endtask

  initial begin
    rst = 1; sd_n = 1; ht_n = 1; clr = 0; lbusy = 0; ebusy = 0; num_in = 0;
    cyc(3);
    // R8: reset state
    chk("R8 rorq", rorq, 0); chk("R8 dump", dump, 0);
    chk("R8 amb", amb, 0); chk("R8 num", num_out, 0);
    rst = 0; cmp_on = 1;
    cyc(4);

    // R1 + R2: hold-transfer first, latency of three edges
    ht_n = 0;
    cyc(2); chk("R1 no early flag", rorq, 0);
    cyc(1); chk("R1 R2 rorq set", rorq, 1); chk("R2 dump clear", dump, 0);
    sd_n = 0; cyc(4); chk("R2 no dump after", dump, 0);
    // R5: number captured on return high
    num_in = 16'hA5C3; ht_n = 1;
    cyc(2); chk("R5 not yet", num_out, 0);
    cyc(1); chk("R5 captured", num_out, 16'hA5C3);
    num_in = 16'h1234; cyc(4); chk("R5 held", num_out, 16'hA5C3);
    sd_n = 1; cyc(4); chk("R2 sticky", rorq, 1);
    // R4: clear
    pulse_clr(); chk("R4 rorq cleared", rorq, 0); chk("R4 dump cleared", dump, 0);

    // R3: start-digitize first
    sd_n = 0; cyc(3); chk("R3 dump set", dump, 1); chk("R3 rorq clear", rorq, 0);
    ht_n = 0; cyc(4); chk("R3 no rorq", rorq, 0);
    idle_lines(); pulse_clr();

    // R6: simultaneous falls
    sd_n = 0; ht_n = 0; cyc(3);
    chk("R6 amb pulse", amb, 1); cyc(1); chk("R6 amb one cycle", amb, 0);
    chk("R6 no rorq", rorq, 0); chk("R6 no dump", dump, 0);
    idle_lines();

    // R9: clear coincides with the deciding edge
    ht_n = 0; cyc(2); clr = 1; cyc(1); clr = 0;
    chk("R9 clear wins", rorq, 0); cyc(3); chk("R9 stays clear", rorq, 0);
    idle_lines();

    // R10: one decision per trigger, then re-arm
    ht_n = 0; cyc(4); chk("R10 first decision", rorq, 1);
    ht_n = 1; sd_n = 0; cyc(1); ht_n = 0; cyc(4);
    chk("R10 no second decision", dump, 0);
    idle_lines(); sd_n = 0; cyc(4); chk("R10 rearmed dump", dump, 1);
    idle_lines(); pulse_clr();

    // R7: busy combinations
    for (int i = 0; i < 4; i++) begin
      lbusy = i[0]; ebusy = i[1]; cyc(1);
      chk("R7 busy or", busy, (i != 0) ? 1 : 0);
    end

    // Random traffic, checked every cycle against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 9) == 0) sd_n = ~sd_n;
      if ($urandom_range(0, 9) == 0) ht_n = ~ht_n;
      if ($urandom_range(0, 5) == 0) num_in = NW'($urandom);
      clr   = ($urandom_range(0, 30) == 0);
      lbusy = $urandom_range(0, 1);
      ebusy = $urandom_range(0, 1);
      cyc(1);
    end
    clr = 0;
    cyc(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule